// File: doc/BRIEF.md
# Serial Port Interrupt Identification Logic

This block collects the four interrupt causes of a PC-style serial port and turns them into one prioritised report. The causes are line-status error, received data, transmitter holding register empty and modem-status change. It holds the interrupt enable register and builds the read value of the interrupt identification register. It also drives one interrupt request line, which passes through a gate controlled by a modem-control output bit.

Other parts of the port report events to this block. The receiver, the line-error checker and the modem-status change detector each send a one-cycle event pulse. The transmitter sends the level of its holding-register-empty flag. Register-access logic sends the read and write strobes that clear causes. Each cause is held as a pending flag. The enable mask is applied to the pending flags combinationally, so the identification value always reflects the current state.

Top module: `uart_irq_ident`

## Requirements
- R1: A write to the enable register stores bits 3:0 of the written byte. Bit 0 enables received data, bit 1 enables transmitter empty, bit 2 enables line-status error and bit 3 enables modem status. Bits 7:4 of the enable read value are always 0.
- R2: Bit 0 of the identification value is 0 when an enabled cause is pending and 1 when none is. Bits 7:3 are always 0.
- R3: Bits 2:1 of the identification value name the highest-priority enabled pending cause. The codes are 11 for line-status error, 10 for received data, 01 for transmitter empty and 00 for modem status, and the priority runs in that order from highest to lowest. With nothing pending, bits 2:1 read 00.
- R4: A pending cause whose enable bit is 0 is not reported and does not raise the request line. It stays pending, and it is reported as soon as its enable bit is set again.
- R5: The line-status cause clears on a line-status read strobe. The received-data cause clears on a receive-buffer read strobe. The modem cause clears on a modem-status read strobe. Each clear takes effect from the next cycle.
- R6: The transmitter cause sets when the holding-empty flag goes from 0 to 1. It clears on a holding-register write strobe.
- R7: An identification read strobe clears the transmitter cause only when transmitter empty is the reported source in that cycle. Otherwise the read leaves every cause unchanged.
- R8: The request output is 1 exactly when an enabled cause is pending and the gate bit is 1.
- R9: When a set event and the clear strobe of the same cause arrive in the same cycle, the cause is pending afterwards.
- R10: After reset, the enable register is 0, no cause is pending, the identification value is 0x01 and the request output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | REG_W | Enable register write data |
| ier_rdata | output | REG_W | Enable register read value |
| iir_rd | input | 1 | Identification register read strobe |
| iir_rdata | output | REG_W | Identification register read value |
| rx_avail_evt | input | 1 | Received-data-available event pulse |
| rbr_rd | input | 1 | Receive buffer read strobe |
| line_err_evt | input | 1 | Line-status error event pulse |
| lsr_rd | input | 1 | Line status read strobe |
| thr_empty | input | 1 | Transmit holding register empty level |
| thr_wr | input | 1 | Transmit holding register write strobe |
| modem_chg_evt | input | 1 | Modem-status change event pulse |
| msr_rd | input | 1 | Modem status read strobe |
| out2 | input | 1 | Modem-control gate bit for the request line |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a transmitter cause that is pending but hidden behind a higher-priority cause while the identification register is read. Only that arrangement shows that the read clears the transmitter cause only when it is the reported source. The bench sets the transmitter cause and a line-status cause together and reads the identification register. It then clears the line-status cause and checks that transmitter empty shows through. A full sweep covers every pending pattern against every enable mask and both gate values. Further directed cases cover a set arriving together with its clear, and a source being masked and unmasked.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 4;

    // Enable-register bit positions (also index of each cause in vectors)
    localparam int IDX_RX    = 0;
    localparam int IDX_TX    = 1;
    localparam int IDX_LINE  = 2;
    localparam int IDX_MODEM = 3;

    typedef enum logic [1:0] {
        SRC_MODEM = 2'b00,
        SRC_TX    = 2'b01,
        SRC_RX    = 2'b10,
        SRC_LINE  = 2'b11
    } irq_src_e;

    function automatic irq_src_e src_code(input int idx);
        case (idx)
            IDX_LINE: return SRC_LINE;
            IDX_RX:   return SRC_RX;
            IDX_TX:   return SRC_TX;
            default:  return SRC_MODEM;
        endcase
    endfunction

    // Rank of each cause; larger wins
    function automatic int src_rank(input int idx);
        case (idx)
            IDX_LINE: return 3;
            IDX_RX:   return 2;
            IDX_TX:   return 1;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_cause.sv
module uart_irq_cause (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_i) pend_d = 1'b0;
        if (set_i) pend_d = 1'b1;   // a new event is never lost
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] active_i,
    output logic               any_o,
    output irq_src_e           src_o
);
    always_comb begin
        int best_rank;
        any_o     = 1'b0;
        src_o     = SRC_MODEM;
        best_rank = -1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active_i[i] && src_rank(i) > best_rank) begin
                best_rank = src_rank(i);
                src_o     = src_code(i);
                any_o     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [REG_W-1:0] ier_wdata,
    output logic [REG_W-1:0] ier_rdata,
    input  logic             iir_rd,
    output logic [REG_W-1:0] iir_rdata,
    input  logic             rx_avail_evt,
    input  logic             rbr_rd,
    input  logic             line_err_evt,
    input  logic             lsr_rd,
    input  logic             thr_empty,
    input  logic             thr_wr,
    input  logic             modem_chg_evt,
    input  logic             msr_rd,
    input  logic             out2,
    output logic             irq
);
    typedef struct packed {
        logic [NUM_SRC-1:0] ier;
        logic               thr_empty_seen;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_SRC-1:0] set_vec, clr_vec, pend_vec, active_vec;
    logic               any_pend;
    irq_src_e           cur_src;

    // Control state: next value
    always_comb begin
        ctl_d                = ctl_q;
        ctl_d.thr_empty_seen = thr_empty;
        if (ier_wr) ctl_d.ier = ier_wdata[NUM_SRC-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Set and clear conditions of each cause
    always_comb begin
        set_vec            = '0;
        clr_vec            = '0;
        set_vec[IDX_RX]    = rx_avail_evt;
        clr_vec[IDX_RX]    = rbr_rd;
        set_vec[IDX_LINE]  = line_err_evt;
        clr_vec[IDX_LINE]  = lsr_rd;
        set_vec[IDX_MODEM] = modem_chg_evt;
        clr_vec[IDX_MODEM] = msr_rd;
        set_vec[IDX_TX]    = thr_empty && !ctl_q.thr_empty_seen;
        clr_vec[IDX_TX]    = thr_wr || (iir_rd && any_pend && cur_src == SRC_TX);
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cause
        uart_irq_cause u_cause (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[g]),
            .clr_i  (clr_vec[g]),
            .pend_o (pend_vec[g])
        );
    end

    assign active_vec = pend_vec & ctl_q.ier;

    uart_irq_prio u_prio (
        .active_i (active_vec),
        .any_o    (any_pend),
        .src_o    (cur_src)
    );

    always_comb begin
        ier_rdata              = '0;
        ier_rdata[NUM_SRC-1:0] = ctl_q.ier;
        iir_rdata              = '0;
        iir_rdata[0]           = !any_pend;
        iir_rdata[2:1]         = cur_src;
    end

    assign irq = any_pend && out2;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ier_wr,
    input logic [REG_W-1:0] ier_wdata,
    input logic [REG_W-1:0] ier_rdata,
    input logic             iir_rd,
    input logic [REG_W-1:0] iir_rdata,
    input logic             rx_avail_evt,
    input logic             rbr_rd,
    input logic             line_err_evt,
    input logic             lsr_rd,
    input logic             thr_empty,
    input logic             thr_wr,
    input logic             modem_chg_evt,
    input logic             msr_rd,
    input logic             out2,
    input logic             irq
);
    a_r1_ier_write: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> ier_rdata[3:0] == $past(ier_wdata[3:0]));

    a_r8_irq_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (out2 && !iir_rdata[0]));

    a_r8_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (out2 && !iir_rdata[0]) |-> irq);

    a_r5_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !line_err_evt) |=> (iir_rdata[0] || iir_rdata[2:1] != 2'b11));

    a_r6_thr_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thr_empty) |=> (iir_rdata[2:0] != 3'b010));

    a_r9_line_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err_evt && ier_rdata[2] && !ier_wr) |=> (iir_rdata[2:0] == 3'b110));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 1'b0;
    logic [7:0] ier_wdata = '0;
    logic [7:0] ier_rdata;
    logic       iir_rd = 1'b0;
    logic [7:0] iir_rdata;
    logic       rx_avail_evt = 1'b0, rbr_rd = 1'b0;
    logic       line_err_evt = 1'b0, lsr_rd = 1'b0;
    logic       thr_empty = 1'b0, thr_wr = 1'b0;
    logic       modem_chg_evt = 1'b0, msr_rd = 1'b0;
    logic       out2 = 1'b0;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    uart_irq_ident u_uart_irq_ident (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle;
        ier_wr = 0; iir_rd = 0; rx_avail_evt = 0; rbr_rd = 0; line_err_evt = 0;
        lsr_rd = 0; thr_wr = 0; modem_chg_evt = 0; msr_rd = 0;
    endtask

    // Clear every cause; leaves thr_empty low
    task automatic clear_all;
        idle();
        rbr_rd = 1; lsr_rd = 1; msr_rd = 1; thr_wr = 1; thr_empty = 0;
        @(negedge clk);
        idle();
    endtask

    // Set causes by pattern (bit0 rx, bit1 tx, bit2 line, bit3 modem)
    task automatic set_pat(input logic [3:0] p);
        rx_avail_evt = p[0]; thr_empty = p[1]; line_err_evt = p[2]; modem_chg_evt = p[3];
        @(negedge clk);
        idle();
    endtask

    task automatic write_ier(input logic [7:0] v);
        ier_wr = 1; ier_wdata = v;
        @(negedge clk);
        idle();
    endtask

    function automatic logic [7:0] exp_iir(input logic [3:0] act);
        if (act[2])      return 8'h06;
        else if (act[0]) return 8'h04;
        else if (act[1]) return 8'h02;
        else if (act[3]) return 8'h00;
        else             return 8'h01;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk("R10 iir", iir_rdata, 8'h01);
        chk("R10 ier", ier_rdata, 8'h00);
        chk("R10 irq", {7'b0, irq}, 8'h00);

        // Sweep: every pending pattern x enable mask x gate (R1 R2 R3 R4 R8)
        for (int p = 0; p < 16; p++) begin
            for (int e = 0; e < 16; e++) begin
                for (int o = 0; o < 2; o++) begin
                    logic [3:0] act;
                    clear_all();
                    out2 = o[0];
                    ier_wr = 1; ier_wdata = {p[3:0], e[3:0]};
                    set_pat(p[3:0]);
                    act = p[3:0] & e[3:0];
                    chk("R1 ier readback", ier_rdata, {4'h0, e[3:0]});
                    chk("R2/R3/R4 iir", iir_rdata, exp_iir(act));
                    chk("R8 irq", {7'b0, irq}, {7'b0, (act != 0) && o[0]});
                end
            end
        end
        out2 = 1;

        // R4: masked then unmasked
        clear_all();
        write_ier(8'h00);
        set_pat(4'hF);
        chk("R4 masked", iir_rdata, 8'h01);
        write_ier(8'h0F);
        chk("R4 unmasked", iir_rdata, 8'h06);

        // R5: clears in turn
        lsr_rd = 1; @(negedge clk); idle();
        chk("R5 line cleared", iir_rdata, 8'h04);
        rbr_rd = 1; @(negedge clk); idle();
        chk("R5 rx cleared", iir_rdata, 8'h02);
        thr_wr = 1; thr_empty = 0; @(negedge clk); idle();
        chk("R6 thr write clears", iir_rdata, 8'h00);
        msr_rd = 1; @(negedge clk); idle();
        chk("R5 modem cleared", iir_rdata, 8'h01);
        thr_empty = 1; @(negedge clk);
        chk("R6 thr empty rise sets", iir_rdata, 8'h02);
        @(negedge clk);
        chk("R6 no retrigger on level", iir_rdata, 8'h02);

        // R7: read clears tx when reported
        clear_all();
        set_pat(4'b1010);
        chk("R7 tx reported", iir_rdata, 8'h02);
        iir_rd = 1; @(negedge clk); idle();
        chk("R7 tx cleared by read", iir_rdata, 8'h00);

        // R7: read does not clear tx hidden behind line
        clear_all();
        set_pat(4'b0110);
        chk("R7 line over tx", iir_rdata, 8'h06);
        iir_rd = 1; @(negedge clk); idle();
        chk("R7 read keeps causes", iir_rdata, 8'h06);
        lsr_rd = 1; @(negedge clk); idle();
        chk("R7 tx still pending", iir_rdata, 8'h02);

        // R9: set and clear together
        clear_all();
        line_err_evt = 1; lsr_rd = 1; @(negedge clk); idle();
        chk("R9 line set wins", iir_rdata, 8'h06);
        rx_avail_evt = 1; rbr_rd = 1; lsr_rd = 1; @(negedge clk); idle();
        chk("R9 rx set wins", iir_rdata, 8'h04);
        chk("R8 irq gate on", {7'b0, irq}, 8'h01);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule